// File: doc/BRIEF.md
# Two-Vector Testable Conservative Master-Slave D Flip-Flop

This block is a single-bit D flip-flop built from conservative three-line controlled-swap gates. A controlled-swap gate passes its two data lines straight through when its control line is 0. It exchanges them when the control line is 1. Two such gates form a latch cell. The first gate picks either the incoming data or the fed-back stored value, depending on the clock level. The second gate makes the fan-out copy of the stored value plus a complement line, and that copy is the feedback.

Each latch cell has its own two-bit control pair. The master cell is transparent while the clock is high. The slave cell is transparent while the clock is low. Because the slave's enable polarity comes from the order of the data lines on its first gate, no clock inverter is needed. The pair 0,1 gives normal operation. Under the pair 0,1 the flip-flop captures D on the falling clock edge, since that is where the master closes and the slave opens.

Setting every control and the data input to one common value breaks both feedback paths. The all-0 vector then drives every observable line to 0 and exposes stuck-at-1 faults. The all-1 vector exposes stuck-at-0 faults. Two parameters place one stuck-at fault on a chosen internal net so that the test procedure can be exercised.

Top module: `rev_msdff`

## Requirements
- R1: The controlled-swap gate gives x=b, y=c when its control a is 0, and x=c, y=b when a is 1. The number of ones on {x,y} always equals the number on {b,c}.
- R2: With both control pairs normal (bit0=0, bit1=1, i.e. 2'b10), q_o takes after each falling clock edge the value d_i had just before that edge. qn_o takes its complement.
- R3: In normal mode, q_o does not change at the rising edge or during the high phase, even when d_i changes while the clock is high. The master cell holds its value and its complement line while the clock is low.
- R4: In normal mode, qn_o is always the inverse of q_o.
- R5: While rst_ni is low, both stored nodes are cleared, so q_o=0 and qn_o=1 in normal mode at either clock level. The first falling edge after release captures d_i.
- R6: With both control pairs at 2'b00, q_o=0 and qn_o=0 at either clock level, whatever d_i is.
- R7: With both control pairs at 2'b11, q_o=1 and qn_o=1 at either clock level, whatever d_i is.
- R8: FAULT_SITE selects one net to force to FAULT_VAL. The codes are 0 for none, 1 for the master data path, 2 for the master feedback, 3 for the slave data path, 4 for the slave feedback, 5 for q_o and 6 for qn_o. A stuck-at-1 fault makes {q_o,qn_o} differ from 2'b00 under the all-0 vector, in at least one clock phase. A stuck-at-0 fault makes {q_o,qn_o} differ from 2'b11 under the all-1 vector, in at least one clock phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; enables the master when high and the slave when low |
| rst_ni | input | 1 | Active-low asynchronous clear of both stored nodes |
| d_i | input | 1 | Data input |
| mst_ctl_i | input | 2 | Master control pair, bit0 first, bit1 second |
| slv_ctl_i | input | 2 | Slave control pair, bit0 first, bit1 second |
| q_o | output | 1 | Flip-flop output |
| qn_o | output | 1 | Complement line from the slave copy gate (garbage line in test mode) |

## Verification
The bench builds one fault-free copy with FAULT_SITE=0. Next to it, a generate loop builds twelve copies that cover every site code 1 to 6 with both FAULT_VAL settings. All thirteen copies share the same stimulus. The fault-free copy is checked for falling-edge capture under random data, including mid-high-phase data changes. The faulty copies must be told apart from the expected all-0 and all-1 responses, sampled at both clock levels, so the sa1/sa0 pairing for every site is reached in one run. A separate gate instance is swept over all eight input patterns.

// File: rtl/rev_msdff_pkg.sv
package rev_msdff_pkg;
  localparam int unsigned SITE_NONE   = 0;
  localparam int unsigned SITE_M_DATA = 1;
  localparam int unsigned SITE_M_FB   = 2;
  localparam int unsigned SITE_S_DATA = 3;
  localparam int unsigned SITE_S_FB   = 4;
  localparam int unsigned SITE_Q      = 5;
  localparam int unsigned SITE_QN     = 6;

  localparam logic [1:0] CTL_NORM = 2'b10;
  localparam logic [1:0] CTL_ALL0 = 2'b00;
  localparam logic [1:0] CTL_ALL1 = 2'b11;

  function automatic logic stick(input logic v, input int unsigned here,
                                 input int unsigned fsite, input bit fval);
    return (fsite == here) ? fval : v;
  endfunction
endpackage

// File: rtl/rev_fredkin.sv
module rev_fredkin (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic x_o,
  output logic y_o
);
  // a=0 passes, a=1 swaps
  assign x_o = a_i ? c_i : b_i;
  assign y_o = a_i ? b_i : c_i;
endmodule

// File: rtl/rev_tlatch.sv
module rev_tlatch #(
  parameter bit          POS_EN     = 1'b1,
  parameter int unsigned SITE_DATA  = 0,
  parameter int unsigned SITE_FB    = 0,
  parameter int unsigned FAULT_SITE = 0,
  parameter bit          FAULT_VAL  = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       d_i,
  input  logic [1:0] ctl_i,
  output logic       q_o,
  output logic       qb_o
);
  import rev_msdff_pkg::*;

  localparam bit CLEAN = (FAULT_SITE == SITE_NONE);

  logic hold_q;
  logic fb;
  logic sel_b, sel_c;
  logic g1_x, g1_y;
  logic g2_x;

  // enable polarity set by data line order, no clock inverter
  generate
    if (POS_EN) begin : g_pos
      assign sel_b = fb;
      assign sel_c = d_i;
    end else begin : g_neg
      assign sel_b = d_i;
      assign sel_c = fb;
    end
  endgenerate

  rev_fredkin u_sel (
    .a_i(clk_i), .b_i(sel_b), .c_i(sel_c), .x_o(g1_x), .y_o(g1_y)
  );

  // stored node: the only state element of the cell
  always_latch begin
    if (!rst_ni)                hold_q <= 1'b0;
    else if (clk_i == POS_EN)   hold_q <= d_i;
  end

  // copy gate: pair 0,1 copies, 0,0 / 1,1 force the feedback
  rev_fredkin u_cpy (
    .a_i(hold_q), .b_i(ctl_i[0]), .c_i(ctl_i[1]), .x_o(g2_x), .y_o(qb_o)
  );

  assign fb  = stick(g2_x, SITE_FB,   FAULT_SITE, FAULT_VAL);
  assign q_o = stick(g1_x, SITE_DATA, FAULT_SITE, FAULT_VAL);

  always_comb begin
    if (CLEAN && !$isunknown({clk_i, sel_b, sel_c})) begin
      AST_SEL_CONSERVE: assert ($countones({sel_b, sel_c}) == $countones({g1_x, g1_y}))
        else $error("selector gate lost a one"); // R1
    end
    if (CLEAN && !$isunknown({hold_q, ctl_i})) begin
      AST_CPY_CONSERVE: assert ($countones(ctl_i) == $countones({g2_x, qb_o}))
        else $error("copy gate lost a one"); // R1
    end
  end
endmodule

// File: rtl/rev_msdff.sv
module rev_msdff #(
  parameter int unsigned FAULT_SITE = 0,
  parameter bit          FAULT_VAL  = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       d_i,
  input  logic [1:0] mst_ctl_i,
  input  logic [1:0] slv_ctl_i,
  output logic       q_o,
  output logic       qn_o
);
  import rev_msdff_pkg::*;

  localparam bit CLEAN = (FAULT_SITE == SITE_NONE);

  logic m_q, m_qb;
  logic s_q, s_qb;

  rev_tlatch #(
    .POS_EN(1'b1), .SITE_DATA(SITE_M_DATA), .SITE_FB(SITE_M_FB),
    .FAULT_SITE(FAULT_SITE), .FAULT_VAL(FAULT_VAL)
  ) u_mst (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(d_i), .ctl_i(mst_ctl_i),
    .q_o(m_q), .qb_o(m_qb)
  );

  rev_tlatch #(
    .POS_EN(1'b0), .SITE_DATA(SITE_S_DATA), .SITE_FB(SITE_S_FB),
    .FAULT_SITE(FAULT_SITE), .FAULT_VAL(FAULT_VAL)
  ) u_slv (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(m_q), .ctl_i(slv_ctl_i),
    .q_o(s_q), .qb_o(s_qb)
  );

  assign q_o  = stick(s_q,  SITE_Q,  FAULT_SITE, FAULT_VAL);
  assign qn_o = stick(s_qb, SITE_QN, FAULT_SITE, FAULT_VAL);

  logic norm;
  assign norm = (mst_ctl_i == CTL_NORM) && (slv_ctl_i == CTL_NORM);

  AST_FALL_CAPTURE: assert property (@(negedge clk_i) disable iff (!rst_ni || !CLEAN)
    (norm && $past(norm) && $past(rst_ni)) |-> (q_o == $past(d_i))); // R2

  AST_MST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || !CLEAN)
    (mst_ctl_i == CTL_NORM) |-> (m_qb == !m_q)); // R3

  AST_QN_COMPL: assert property (@(posedge clk_i) disable iff (!rst_ni || !CLEAN)
    norm |-> (qn_o == !q_o)); // R4

  AST_ALL0_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni || !CLEAN)
    (mst_ctl_i == CTL_ALL0 && slv_ctl_i == CTL_ALL0) |-> (!q_o && !qn_o)); // R6

  AST_ALL1_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni || !CLEAN)
    (mst_ctl_i == CTL_ALL1 && slv_ctl_i == CTL_ALL1) |-> (q_o && qn_o)); // R7
endmodule

// File: tb/sim_rev_msdff.sv
module sim_rev_msdff;
  localparam int NF = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic d = 1'b1;
  logic [1:0] mc = 2'b10;
  logic [1:0] sc = 2'b10;
  logic q, qn;
  logic [NF-1:0] fq, fqn;
  logic [NF-1:0] det0 = '0, det1 = '0;
  int checks = 0;
  int errors = 0;

  logic ga, gb, gc, gx, gy;

  always #10 clk = ~clk;

  rev_msdff u0 (
    .clk_i(clk), .rst_ni(rst_ni), .d_i(d), .mst_ctl_i(mc), .slv_ctl_i(sc),
    .q_o(q), .qn_o(qn)
  );

  for (genvar k = 0; k < NF; k++) begin : g_f
    rev_msdff #(.FAULT_SITE(k/2 + 1), .FAULT_VAL(1'(k % 2))) u_f (
      .clk_i(clk), .rst_ni(rst_ni), .d_i(d), .mst_ctl_i(mc), .slv_ctl_i(sc),
      .q_o(fq[k]), .qn_o(fqn[k])
    );
  end

  rev_fredkin u_g (.a_i(ga), .b_i(gb), .c_i(gc), .x_o(gx), .y_o(gy));

  function automatic logic [1:0] gate_ref(input logic a, input logic b, input logic c);
    return a ? {c, b} : {b, c};
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic sample_vec(input bit v, input bit dv);
    chk(v ? "R7" : "R6", {q, qn}, {v, v});
    if (dv == v)
      for (int k = 0; k < NF; k++)
        if ({fq[k], fqn[k]} !== {v, v}) begin
          if (v) det1[k] = 1'b1;
          else   det0[k] = 1'b1;
        end
  endtask

  task automatic run_vec(input bit v, input bit dv);
    @(posedge clk); #5;
    mc = {v, v}; sc = {v, v}; d = dv;
    repeat (2) begin
      @(posedge clk); #3 sample_vec(v, dv);
      #10 sample_vec(v, dv);
    end
  endtask

  initial begin : watchdog
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    logic expq;
    logic r1, r2;
    void'($urandom(32'd4242));

    // R1: exhaustive gate sweep
    for (int i = 0; i < 8; i++) begin
      {ga, gb, gc} = 3'(i);
      #1 chk("R1", {gx, gy}, gate_ref(ga, gb, gc));
    end

    // R5: reset state in both phases
    repeat (2) @(posedge clk);
    #3 chk("R5", {q, qn}, 2'b01);
    #10 chk("R5", {q, qn}, 2'b01);
    @(posedge clk); #5 rst_ni = 1'b1; d = 1'b1;
    #10 chk("R5", {q, qn}, 2'b10);
    expq = 1'b1;

    // R2/R3/R4: random data, extra change inside the high phase
    for (int i = 0; i < 200; i++) begin
      r1 = 1'($urandom);
      r2 = (i % 16 == 3) ? ~expq : 1'($urandom);
      @(posedge clk);
      #3 chk("R3", {1'b0, q}, {1'b0, expq});
      #2 d = r1;
      #3 d = r2;
      #1 chk("R3", {1'b0, q}, {1'b0, expq});
      #6 chk("R2", {q, qn}, {r2, ~r2});
      chk("R4", {1'b0, qn}, {1'b0, ~q});
      expq = r2;
    end

    // R6/R7/R8: two-vector test with D both agreeing and disagreeing
    run_vec(1'b0, 1'b1);
    run_vec(1'b0, 1'b0);
    run_vec(1'b1, 1'b0);
    run_vec(1'b1, 1'b1);

    // back to normal: next fall captures D
    @(posedge clk); #5 mc = 2'b10; sc = 2'b10; d = 1'b0;
    #10 chk("R2", {q, qn}, 2'b01);

    for (int k = 0; k < NF; k++) begin
      if (k % 2 == 1) chk("R8 sa1 seen by all-0", {1'b0, det0[k]}, 2'b01);
      else            chk("R8 sa0 seen by all-1", {1'b0, det1[k]}, 2'b01);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule